// File: doc/BRIEF.md
# Byte-Lane Masked Interrupt Aggregator

This block gathers four event sources into a sixteen-bit event status word and holds them until software clears them. It compares that word against a sixteen-bit mask and drives a single level-sensitive interrupt line. Three of the sources are single-cycle pulses from a real-time-clock block: a periodic tick, an alarm match and an update error. The fourth is an asynchronous push-button pin, which is synchronised and recognised only on its rising edge.

Software reaches the block through a byte-wide register port with a 3-bit address. The mask, the status word and the acknowledge (write-one-to-clear) function each appear as a low byte and a high byte. A write to one byte affects only that byte lane. Three plain input pins are sampled into a readable pin register and never raise an event.

Register map (`reg_addr_i`): 0 mask low, 1 mask high, 2 status low, 3 status high, 4 acknowledge low, 5 acknowledge high, 6 pin register, 7 unused (reads 0). Reads are combinational from the addressed register. A write takes effect at the clock edge on which `reg_wr_i` is high.

Top module: `irq_byte_agg`

## Requirements
- R1: After reset the mask is 0x0FFF (mask low reads 0xFF, mask high reads 0x0F), the status is 0 and `irq_o` is low.
- R2: `irq_o` is high exactly when some status bit is set whose mask bit is 0. It follows every status, mask or acknowledge change in the same cycle the register changes, with no extra delay.
- R3: A write to mask low replaces mask bits 7:0 only. A write to mask high replaces mask bits 15:8 only.
- R4: A write to acknowledge low clears each status bit 7:0 whose written bit is 1. A write to acknowledge high does the same for status bits 15:8. Other bits are unchanged.
- R5: Both acknowledge addresses read as 0x00.
- R6: A tick pulse sets status bit 8, an alarm pulse sets bit 9 and an update-error pulse sets bit 10. A pulse sampled high at a clock edge shows in the status at that edge (status high reads bits 15:8).
- R7: A low-to-high change on `btn_i` sets status bit 11 on the third rising clock edge after the pin rises. This covers two synchroniser flops and one edge flop. Holding the pin high does not set the bit again after it is acknowledged. A later fresh rise sets it again.
- R8: `pins_i` is registered into the pin register, which reads as {5'b0, pins} one clock edge after a change. A pin change never alters the status or `irq_o`.
- R9: If an event and an acknowledge of the same status bit fall on the same edge, the bit stays set.
- R10: Writes to the status addresses have no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| btn_i | input | 1 | Asynchronous push-button pin |
| tick_i | input | 1 | Periodic tick pulse |
| alarm_i | input | 1 | Alarm pulse |
| upd_err_i | input | 1 | Update-error pulse |
| pins_i | input | 3 | Plain input pins |
| irq_o | output | 1 | Level interrupt output |

## Verification
Register writes and the three pulse events land on the edge where they are sampled. The combinational read and `irq_o` reflect them right after that edge, so each table step drives for one edge and reads at the following falling edge. The push button has a three-edge latency. Its check samples after the second edge to confirm the bit is still clear, then after the third edge to confirm it is set. Pin sampling is checked both before and after its single register edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int STAT_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RA_MASK_LO = 3'd0,
        RA_MASK_HI = 3'd1,
        RA_STAT_LO = 3'd2,
        RA_STAT_HI = 3'd3,
        RA_ACK_LO  = 3'd4,
        RA_ACK_HI  = 3'd5,
        RA_PINS    = 3'd6,
        RA_SPARE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
    } agg_state_t;

endpackage

// File: rtl/irq_rise_sync.sv
module irq_rise_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    localparam int TOTAL = STAGES + 1;

    logic [TOTAL-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[TOTAL-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    // last synchronised stage high while the edge flop still holds low
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import irq_agg_pkg::*;
#(
    parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] set_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o
);
    agg_state_t st_d, st_q;
    logic [STAT_W-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr_i) begin
            unique case (reg_addr_e'(addr_i))
                RA_MASK_LO: st_d.mask[BYTE_W-1:0]      = wdata_i;
                RA_MASK_HI: st_d.mask[STAT_W-1:BYTE_W] = wdata_i;
                RA_ACK_LO:  clr[BYTE_W-1:0]            = wdata_i;
                RA_ACK_HI:  clr[STAT_W-1:BYTE_W]       = wdata_i;
                default: ;
            endcase
        end
        // a new event takes precedence over a clear of the same bit
        st_d.status = (st_q.status & ~clr) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.status <= '0;
            st_q.mask   <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
endmodule

// File: rtl/irq_byte_agg.sv
module irq_byte_agg
    import irq_agg_pkg::*;
#(
    parameter int PIN_W     = 3,
    parameter int SYNC_LEN  = 2,
    parameter int TICK_BIT  = 8,
    parameter int ALARM_BIT = 9,
    parameter int ERR_BIT   = 10,
    parameter int BTN_BIT   = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_wr_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             btn_i,
    input  logic             tick_i,
    input  logic             alarm_i,
    input  logic             upd_err_i,
    input  logic [PIN_W-1:0] pins_i,
    output logic             irq_o
);
    localparam int PAD_W = BYTE_W - PIN_W;

    logic              btn_rise;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] status_w, mask_w;
    logic [PIN_W-1:0]  pins_d, pins_q;

    irq_rise_sync #(.STAGES(SYNC_LEN)) u_btn (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (btn_i),
        .rise_o (btn_rise)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[TICK_BIT]  = tick_i;
        set_vec[ALARM_BIT] = alarm_i;
        set_vec[ERR_BIT]   = upd_err_i;
        set_vec[BTN_BIT]   = btn_rise;
    end

    irq_status_core u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .set_i    (set_vec),
        .status_o (status_w),
        .mask_o   (mask_w)
    );

    always_comb pins_d = pins_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pins_q <= '0;
        else         pins_q <= pins_d;
    end

    always_comb begin
        unique case (reg_addr_e'(reg_addr_i))
            RA_MASK_LO: reg_rdata_o = mask_w[BYTE_W-1:0];
            RA_MASK_HI: reg_rdata_o = mask_w[STAT_W-1:BYTE_W];
            RA_STAT_LO: reg_rdata_o = status_w[BYTE_W-1:0];
            RA_STAT_HI: reg_rdata_o = status_w[STAT_W-1:BYTE_W];
            RA_PINS:    reg_rdata_o = {{PAD_W{1'b0}}, pins_q};
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_w & ~mask_w);
endmodule

// File: rtl/irq_byte_agg_chk.sv
module irq_byte_agg_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        reg_wr_i,
    input logic [2:0]  reg_addr_i,
    input logic [7:0]  reg_wdata_i,
    input logic [7:0]  reg_rdata_o,
    input logic        tick_i,
    input logic        alarm_i,
    input logic        upd_err_i,
    input logic        irq_o,
    input logic [15:0] status_w,
    input logic [15:0] mask_w
);
    p_irq_needs_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status_w != 16'h0));

    p_mask_lo_keeps_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 3'd0) |=> (mask_w[15:8] == $past(mask_w[15:8])));

    p_mask_hi_keeps_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 3'd1) |=> (mask_w[7:0] == $past(mask_w[7:0])));

    p_ack_lo_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 3'd4) |=> ((status_w[7:0] & $past(reg_wdata_i)) == 8'h0));

    p_ack_reads_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == 3'd4 || reg_addr_i == 3'd5) |-> (reg_rdata_o == 8'h0));

    p_tick_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> status_w[8]);

    p_alarm_beats_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_i && reg_wr_i && reg_addr_i == 3'd5 && reg_wdata_i[1]) |=> status_w[9]);

    p_status_write_ro_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && (reg_addr_i == 3'd2 || reg_addr_i == 3'd3))
            |=> (status_w[7:0] == $past(status_w[7:0])));
endmodule

bind irq_byte_agg irq_byte_agg_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .tick_i      (tick_i),
    .alarm_i     (alarm_i),
    .upd_err_i   (upd_err_i),
    .irq_o       (irq_o),
    .status_w    (status_w),
    .mask_w      (mask_w)
);

// File: tb/test_irq_byte_agg.sv
module test_irq_byte_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd7;
    logic [7:0] wdata = 8'h0;
    logic [7:0] rdata;
    logic       btn = 1'b0, tick = 1'b0, alarm = 1'b0, uerr = 1'b0;
    logic [2:0] pins = 3'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_byte_agg i_irq_byte_agg (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .btn_i(btn), .tick_i(tick),
        .alarm_i(alarm), .upd_err_i(uerr), .pins_i(pins), .irq_o(irq)
    );

    typedef struct packed {
        logic       w;
        logic [2:0] wa;
        logic [7:0] wd;
        logic [2:0] ev;   // {err, alarm, tick}
        logic [2:0] ra;
        logic [7:0] er;
        logic       ei;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd7, 8'h00, 3'b000, 3'd0, 8'hFF, 1'b0},  // R1 mask lo
        '{1'b0, 3'd7, 8'h00, 3'b000, 3'd1, 8'h0F, 1'b0},  // R1 mask hi
        '{1'b0, 3'd7, 8'h00, 3'b000, 3'd3, 8'h00, 1'b0},  // R1 status
        '{1'b1, 3'd0, 8'h00, 3'b000, 3'd1, 8'h0F, 1'b0},  // R3 lo write keeps hi
        '{1'b1, 3'd1, 8'h0A, 3'b000, 3'd0, 8'h00, 1'b0},  // R3 hi write keeps lo
        '{1'b0, 3'd7, 8'h00, 3'b001, 3'd3, 8'h01, 1'b1},  // R6 tick, R2
        '{1'b0, 3'd7, 8'h00, 3'b010, 3'd3, 8'h03, 1'b1},  // R6 alarm
        '{1'b1, 3'd5, 8'h01, 3'b000, 3'd3, 8'h02, 1'b0},  // R4 ack hi, R2 masked
        '{1'b0, 3'd7, 8'h00, 3'b100, 3'd3, 8'h06, 1'b1},  // R6 err
        '{1'b1, 3'd4, 8'hFF, 3'b000, 3'd3, 8'h06, 1'b1},  // R4 lane only
        '{1'b1, 3'd5, 8'h04, 3'b100, 3'd3, 8'h06, 1'b1},  // R9 event wins
        '{1'b1, 3'd1, 8'h0E, 3'b000, 3'd3, 8'h06, 1'b0},  // R2 mask re-eval
        '{1'b0, 3'd7, 8'h00, 3'b000, 3'd4, 8'h00, 1'b0},  // R5 ack lo
        '{1'b0, 3'd7, 8'h00, 3'b000, 3'd5, 8'h00, 1'b0},  // R5 ack hi
        '{1'b1, 3'd3, 8'h00, 3'b000, 3'd3, 8'h06, 1'b0},  // R10 read only
        '{1'b1, 3'd5, 8'hFF, 3'b000, 3'd3, 8'h00, 1'b0}   // R4 clear all
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp,
                      input logic exp_irq);
        addr = a;
        #1;
        check(req, rdata, exp);
        check({req, " irq"}, {7'b0, irq}, {7'b0, exp_irq});
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 3'd7;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            wr = VECS[i].w; addr = VECS[i].wa; wdata = VECS[i].wd;
            {uerr, alarm, tick} = VECS[i].ev;
            @(negedge clk);
            wr = 1'b0; {uerr, alarm, tick} = 3'b000;
            rd(VECS[i].ra, $sformatf("R%0s vec%0d", "x", i), VECS[i].er, VECS[i].ei);
        end

        // R7 push button: unmask, then rise
        wr_reg(3'd1, 8'h00);
        btn = 1'b1;                 // driven before edge E0
        @(negedge clk); @(negedge clk);
        rd(3'd3, "R7 before third edge", 8'h00, 1'b0);
        @(negedge clk);
        rd(3'd3, "R7 third edge", 8'h08, 1'b1);
        wr_reg(3'd5, 8'h08);
        repeat (5) @(negedge clk);
        rd(3'd3, "R7 held no reset", 8'h00, 1'b0);
        btn = 1'b0;
        repeat (4) @(negedge clk);
        btn = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd3, "R7 second rise", 8'h08, 1'b1);
        wr_reg(3'd5, 8'h08);

        // R8 pins
        @(negedge clk);
        pins = 3'b101;
        rd(3'd6, "R8 before edge", 8'h00, 1'b0);
        @(negedge clk);
        rd(3'd6, "R8 after edge", 8'h05, 1'b0);
        rd(3'd3, "R8 no status hi", 8'h00, 1'b0);
        rd(3'd2, "R8 no status lo", 8'h00, 1'b0);

        // R1 reset again after changes
        wr_reg(3'd0, 8'h12);
        rst_n = 1'b0;
        #1;
        rd(3'd0, "R1 re-reset mask lo", 8'hFF, 1'b0);
        rd(3'd1, "R1 re-reset mask hi", 8'h0F, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule